// File: doc/BRIEF.md
# Transaction-Capable SPI Master

This block is an SPI master driven by two write-only registers: a 32-bit configuration word and a 32-bit data word. Writing the data word starts one transfer, which shifts out a programmed number of bits (1 to 32) while the same number of bits is shifted in. The SPI clock runs at the system clock divided by an integer. Clock polarity and phase, bit order, chip-select polarity and 3-wire half-duplex operation can all be chosen.

Several transfers can be chained into one transaction. Chip select is asserted when the first transfer starts. It stays asserted between transfers and is released only when a transfer completes with the end-of-transaction flag set. All settings are copied at the start of each transfer, so a configuration write made between transfers changes only the next one. The one exception is the offline flag, which releases every pin to high impedance on the next cycle. A write made while a transfer is running is dropped and reported on a one-cycle error strobe. When capture is enabled, the received word is presented with a one-cycle valid strobe after the transfer ends.

Top module: `spi_xact_master`

## Requirements
- R1: After reset the offline flag is set, so `sclk_oe`, `mosi_oe` and `cs_oe` are 0. `busy`, `busy_err` and `rd_valid` are 0, and every `cs_o` bit sits at its inactive level (1). The working settings are length 1, divider 2, end set and capture clear, so a data write issued straight after reset keeps `busy` high for 4 cycles and produces no `rd_valid`.
- R2: A data write (`wr_sel`=0) accepted while not busy raises `busy` on the next cycle. `busy` then stays high for exactly (n+1)*div cycles, during which `sclk_o` makes exactly 2n transitions, where n is the bit length.
- R3: The effective divider is the 8-bit field at config[23:16], with values below 2 treated as 2. In each bit period `sclk_o` is at its idle level for ceil(div/2) cycles and at its active level for floor(div/2) cycles, so an odd divider gives the longer half to setup.
- R4: Config bit 6 selects the bit order. When it is clear, the first bit driven is data[31] and the last bit received lands in `rd_data` bit 0. When it is set, the first bit driven is data[0] and the last bit received lands in `rd_data` bit 31. In both cases the input register is cleared at the start of the transfer.
- R5: Config bit 4 sets the idle level of `sclk_o` (CPOL) and config bit 5 sets the phase (CPHA), following the standard SPI modes 0 to 3. With phase 0 the input is sampled on the leading edge and the output changes on the trailing edge. With phase 1 the output changes on the leading edge and the input is sampled on the trailing edge.
- R6: Chip select pattern config[27:24] is asserted when a transfer starts, at the polarity given by config bit 3 (1 = active high). After a transfer with the end flag (bit 1) clear, the pattern stays asserted. After a transfer with the end flag set, every chip select returns to its inactive level.
- R7: A configuration write (`wr_sel`=1) while not busy does not change the current `sclk_o` level, chip select or working settings until the next data write. The exception is the offline flag (config bit 0): setting it drives all three output enables to 0 on the next cycle, and clearing it drives them back to 1. The bit length minus one is held in config[12:8].
- R8: Any write while `busy` is high is ignored and pulses `busy_err` for one cycle. The running transfer keeps its duration and its received data.
- R9: When capture (config bit 2) is set, `rd_valid` pulses for one cycle in the cycle after `busy` falls, with the received word on `rd_data`. When capture is clear, `rd_valid` stays 0.
- R10: With half duplex (config bit 7) set, input is sampled from `mosi_i` instead of `miso_i`. If capture is also set, `mosi_oe` is 0 for the whole transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = data word, 1 = configuration word |
| wr_data | input | 32 | Value to write |
| busy | output | 1 | A transfer is in progress |
| busy_err | output | 1 | One-cycle pulse: a write arrived while busy |
| rd_valid | output | 1 | One-cycle pulse: captured word available |
| rd_data | output | 32 | Received word |
| sclk_o | output | 1 | SPI clock |
| sclk_oe | output | 1 | SPI clock output enable |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Serial data out enable |
| mosi_i | input | 1 | Serial data line read back (half duplex) |
| miso_i | input | 1 | Serial data in (full duplex) |
| cs_o | output | 4 | Chip select lines |
| cs_oe | output | 1 | Chip select output enable |

## Verification
The assertions check these properties on every cycle:
- a write during a transfer always produces the error strobe;
- an accepted data write always raises `busy`;
- toggling the offline flag always moves the output enables on the next cycle;
- `rd_valid` appears only right after a transfer ends;
- `sclk_o` stays still outside transfers;
- the divider counter never reaches the divider value.

Some behaviours only the bench's scenarios can show, because they depend on the data values and on whole-transfer counts:
- bit order and the placement of received bits, checked through a loopback of `mosi_o` into `miso_i`;
- transfer length and edge counts;
- the asymmetric clock halves for odd dividers;
- chip select holding across a multi-transfer transaction;
- deferred polarity changes;
- half-duplex input taken from `mosi_i`.

// File: rtl/spi_xact_master.sv
module spi_xact_master #(
  parameter int DW   = 32,
  parameter int LW   = 5,
  parameter int DIVW = 8,
  parameter int NCS  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic          busy,
  output logic          busy_err,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          sclk_o,
  output logic          sclk_oe,
  output logic          mosi_o,
  output logic          mosi_oe,
  input  logic          mosi_i,
  input  logic          miso_i,
  output logic [NCS-1:0] cs_o,
  output logic          cs_oe
);
  localparam int SW = LW + 1;
  localparam logic [DW-1:0] CFG_RST = (DW'(2) << 16) | DW'(3);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_HOLD} st_t;

  st_t             st;
  logic [DW-1:0]   cfg, act, sh, rx;
  logic [DIVW-1:0] div_cnt;
  logic [SW-1:0]   slot;

  logic            a_end, a_inp, a_cspol, a_cpol, a_cpha, a_lsb, a_hd;
  logic [DIVW-1:0] a_div, div_eff, setup_len;
  logic [SW-1:0]   nbits;
  logic [NCS-1:0]  a_cs;

  assign a_end   = act[1];
  assign a_inp   = act[2];
  assign a_cspol = act[3];
  assign a_cpol  = act[4];
  assign a_cpha  = act[5];
  assign a_lsb   = act[6];
  assign a_hd    = act[7];
  assign a_div   = act[16 +: DIVW];
  assign a_cs    = act[24 +: NCS];
  assign nbits   = {1'b0, act[8 +: LW]} + SW'(1);
  assign div_eff = (a_div < DIVW'(2)) ? DIVW'(2) : a_div;
  assign setup_len = div_eff - (div_eff >> 1);

  logic bit_slot, slot_end, lead_pre, trail_pre, last, smp, shf, din, accept, offline;

  assign busy      = (st == S_XFER);
  assign offline   = cfg[0];
  assign bit_slot  = (slot != '0);
  assign slot_end  = (div_cnt == div_eff - DIVW'(1));
  assign lead_pre  = busy && bit_slot && (div_cnt == setup_len - DIVW'(1));
  assign trail_pre = busy && bit_slot && slot_end;
  assign last      = busy && (slot == nbits) && slot_end;
  assign smp       = a_cpha ? trail_pre : lead_pre;
  assign shf       = a_cpha ? (lead_pre && slot >= SW'(2)) : (trail_pre && slot != nbits);
  assign din       = a_hd ? mosi_i : miso_i;
  assign accept    = wr_en && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cfg      <= CFG_RST;
      act      <= CFG_RST;
      sh       <= '0;
      rx       <= '0;
      div_cnt  <= '0;
      slot     <= '0;
      busy_err <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      busy_err <= wr_en && busy;
      rd_valid <= last && a_inp;
      if (accept && wr_sel) cfg <= wr_data;
      if (accept && !wr_sel) begin
        act     <= cfg;
        sh      <= wr_data;
        rx      <= '0;
        div_cnt <= '0;
        slot    <= '0;
        st      <= S_XFER;
      end else if (busy) begin
        if (slot_end) begin
          div_cnt <= '0;
          slot    <= slot + SW'(1);
        end else begin
          div_cnt <= div_cnt + DIVW'(1);
        end
        if (smp) rx <= a_lsb ? {din, rx[DW-1:1]} : {rx[DW-2:0], din};
        if (shf) sh <= a_lsb ? {1'b0, sh[DW-1:1]} : {sh[DW-2:0], 1'b0};
        if (last) st <= a_end ? S_IDLE : S_HOLD;
      end
    end
  end

  assign rd_data = rx;
  assign sclk_o  = a_cpol ^ (busy && bit_slot && div_cnt >= setup_len);
  assign mosi_o  = a_lsb ? sh[0] : sh[DW-1];
  assign sclk_oe = !offline;
  assign cs_oe   = !offline;
  assign mosi_oe = !offline && !(busy && a_hd && a_inp);

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_o[i] = ((st != S_IDLE) && a_cs[i]) ? a_cspol : !a_cspol;
  end

  a_r8_busy_err: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> busy_err);
  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && !busy) |=> busy);
  a_r7_offline_now: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && !busy && wr_data[0]) |=> (!sclk_oe && !cs_oe && !mosi_oe));
  a_r7_online_now: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && !busy && !wr_data[0]) |=> (sclk_oe && cs_oe));
  a_r9_rd_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!busy && $past(busy)));
  a_r5_sclk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(sclk_o));
  a_r3_div_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (div_cnt < div_eff));
endmodule

// File: tb/tb_spi_xact_master.sv
module tb_spi_xact_master;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, wr_sel = 0;
  logic [31:0] wr_data = '0;
  logic        busy, busy_err, rd_valid, sclk_o, sclk_oe, mosi_o, mosi_oe, cs_oe;
  logic        mosi_i = 0, miso_i;
  logic [31:0] rd_data;
  logic [3:0]  cs_o;

  always #4 clk = ~clk;
  assign miso_i = mosi_o;

  spi_xact_master dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .busy(busy), .busy_err(busy_err), .rd_valid(rd_valid), .rd_data(rd_data),
    .sclk_o(sclk_o), .sclk_oe(sclk_oe), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .mosi_i(mosi_i), .miso_i(miso_i), .cs_o(cs_o), .cs_oe(cs_oe));

  int nchk = 0, nerr = 0;
  int nb, tog, actc, oelow, errs;
  logic rv;
  logic [31:0] rdv;
  logic [3:0] cs_mid, cs_after;

  // {config, data}
  localparam logic [63:0] VEC [8] = '{
    {32'h01020706, 32'hA5C31234},
    {32'h01031F26, 32'h12345678},
    {32'h01040416, 32'hF0F00F0F},
    {32'h01050B76, 32'h00000ABC},
    {32'h01020046, 32'h00000001},
    {32'h01021F66, 32'hDEADBEEF},
    {32'h01010F06, 32'hBEEF0000},
    {32'h01070216, 32'h60000000}
  };

  task automatic chk(input string r, input logic [31:0] a, input logic [31:0] e);
    nchk++;
    if (a !== e) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", r, a, e);
    end
  endtask

  task automatic wcfg(input logic [31:0] c);
    @(negedge clk); wr_en = 1; wr_sel = 1; wr_data = c;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic run(input logic [31:0] d, input logic idle, input int inj);
    logic ps;
    nb = 0; tog = 0; actc = 0; oelow = 0; errs = 0;
    @(negedge clk); wr_en = 1; wr_sel = 0; wr_data = d;
    @(negedge clk); wr_en = 0;
    ps = sclk_o; cs_mid = cs_o;
    while (busy && nb < 5000) begin
      nb++;
      if (sclk_o != ps) tog++;
      ps = sclk_o;
      if (sclk_o != idle) actc++;
      if (!mosi_oe) oelow++;
      if (busy_err) errs++;
      if (nb == inj) begin wr_en = 1; wr_sel = 0; wr_data = 32'hFFFFFFFF; end
      else if (nb == inj + 1) wr_en = 0;
      @(negedge clk);
    end
    if (sclk_o != ps) tog++;
    if (busy_err) errs++;
    rv = rd_valid; rdv = rd_data; cs_after = cs_o;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sclk_oe", 32'(sclk_oe), 0);
    chk("R1 mosi_oe", 32'(mosi_oe), 0);
    chk("R1 cs_oe", 32'(cs_oe), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 busy_err", 32'(busy_err), 0);
    chk("R1 rd_valid", 32'(rd_valid), 0);
    chk("R1 cs idle", 32'(cs_o), 32'hF);
    run(32'h80000000, 1'b0, 0);
    chk("R1 default duration", nb, 4);
    chk("R1 default toggles", tog, 2);
    chk("R1 R9 no capture", 32'(rv), 0);
    chk("R1 still offline", oelow, 4);

    // table of modes: R2 R3 R4 R5 R6 R9
    for (int i = 0; i < 8; i++) begin
      logic [31:0] c, d, e;
      int n, dv;
      logic lsb, cpol;
      c = VEC[i][63:32]; d = VEC[i][31:0];
      n = int'(c[12:8]) + 1;
      dv = (c[23:16] < 2) ? 2 : int'(c[23:16]);
      lsb = c[6]; cpol = c[4];
      e = lsb ? (d << (32 - n)) : (d >> (32 - n));
      wcfg(c);
      run(d, cpol, 0);
      chk("R2 duration", nb, (n + 1) * dv);
      chk("R2 sclk toggles", tog, 2 * n);
      chk("R3 active half", actc, n * (dv / 2));
      chk("R4 R5 loopback data", rdv, e);
      chk("R9 rd_valid", 32'(rv), 1);
      chk("R6 cs during", 32'(cs_mid), 32'hE);
      chk("R6 cs released", 32'(cs_after), 32'hF);
      chk("R8 no spurious err", errs, 0);
    end

    // R7 deferred polarity and immediate offline
    wcfg(32'h01020006);
    run(32'h0, 1'b0, 0);
    wcfg(32'h01020016);
    chk("R7 cpol deferred", 32'(sclk_o), 0);
    run(32'h80000000, 1'b1, 0);
    chk("R7 cpol applied", actc, 1);
    chk("R7 cpol toggles", tog, 2);
    chk("R7 idle after", 32'(sclk_o), 1);
    wcfg(32'h01020017);
    chk("R7 offline sclk_oe", 32'(sclk_oe), 0);
    chk("R7 offline cs_oe", 32'(cs_oe), 0);
    chk("R7 offline mosi_oe", 32'(mosi_oe), 0);
    wcfg(32'h01020016);
    chk("R7 online sclk_oe", 32'(sclk_oe), 1);
    chk("R7 online mosi_oe", 32'(mosi_oe), 1);

    // R6 multi-transfer transaction, active-high chip select
    wcfg(32'h0502070C);
    run(32'hC3000000, 1'b0, 0);
    chk("R6 cs first", 32'(cs_mid), 32'h5);
    chk("R6 cs held", 32'(cs_after), 32'h5);
    chk("R6 data 1", rdv, 32'hC3);
    repeat (5) @(negedge clk);
    chk("R6 cs held later", 32'(cs_o), 32'h5);
    wcfg(32'h0502070E);
    chk("R6 cs held over cfg", 32'(cs_o), 32'h5);
    run(32'h3C000000, 1'b0, 0);
    chk("R6 data 2", rdv, 32'h3C);
    chk("R6 cs released end", 32'(cs_after), 32'h0);

    // R8 write while busy
    wcfg(32'h01040706);
    run(32'h96000000, 1'b0, 5);
    chk("R8 busy_err pulse", errs, 1);
    chk("R8 duration kept", nb, 36);
    chk("R8 data kept", rdv, 32'h96);

    // R10 half duplex
    mosi_i = 1;
    wcfg(32'h01020786);
    run(32'h00000000, 1'b0, 0);
    chk("R10 input from mosi_i", rdv, 32'hFF);
    chk("R10 mosi released", oelow, nb);
    chk("R10 rd_valid", 32'(rv), 1);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule